// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Sequencer

This block brings a PCIe root-port core out of reset in one fixed order after a single start pulse. It holds the endpoint in reset for a fixed time and turns on the interface, PHY and core clocks one after another while the bus-interface reset stays asserted. It then releases that reset and, after a short gap, writes the PHY control, transmit de-emphasis, transmit swing and reference-clock control words. After that it lets the PHY, core, power-on and AXI domain resets go one per cycle. It waits for the clocks to settle, releases the endpoint reset, waits again, writes the system control word that enables link training, and finally samples the link-up status at a fixed interval until the link comes up or the poll budget runs out.

All waits are down-counters whose lengths are microsecond parameters multiplied by a cycles-per-microsecond parameter. This lets a small simulation use short windows and silicon use the real milliseconds. The register-write strobe carries a 3-bit select and a 32-bit value. A decoder beside the core applies the value to the word that the select names. A timeout still ends in the done state, with a sticky flag, so downstream configuration can choose to go on or give up.

Top module: `pcie_bringup_seq`

## Requirements
- R1: After reset, and in idle before any start, all five domain resets are 1, `ep_rst_n_o` is 0, all three clock enables are 0, and `wr_en_o`, `train_en_o`, `busy_o`, `done_o` and `timeout_o` are 0.
- R2: The edge that accepts a start begins an endpoint-reset hold of EP_HOLD_US*CYC_PER_US cycles. The interface clock enable then rises, followed by the PHY clock enable one cycle later and the core clock enable one cycle after that. The bus-interface reset stays 1 during this time.
- R3: The bus-interface reset falls one cycle after the core clock enable rises. No register write occurs for BUS_GAP_US*CYC_PER_US cycles after that.
- R4: The first write has select 0 (PHY control) and value 0x00070000. The termination-offset field at bits 20:16 holds 7 and the power-down bit 0 is clear.
- R5: The second and third writes come on consecutive cycles. The second has select 1 (de-emphasis) and value 0x00181822, with 0x18 at bits 21:16, 0x18 at bits 13:8 and 0x22 at bits 5:0. The third has select 2 (swing) and value 0x00007878, with 0x78 at bits 14:8 and at bits 6:0.
- R6: The fourth write, on the next cycle, has select 3 (reference-clock control) and value 0x00010000, with bit 16 set and bit 12 clear.
- R7: On the cycles after the fourth write, the PHY, core, power-on and AXI resets fall in that order, one per cycle. None rises again until the next start.
- R8: A settle wait of SETTLE_US*CYC_PER_US cycles follows the AXI reset release. Then `ep_rst_n_o` rises and a wait of EP_REL_US*CYC_PER_US cycles follows. After that a single write with select 4 (system control) and value 0x00000001 occurs, and `train_en_o` rises in the same cycle and stays high.
- R9: Link-up is sampled at the end of each POLL_US*CYC_PER_US-cycle interval that starts after the training write. It is not sampled in between. The first high sample ends the sequence with `done_o` 1 and `timeout_o` 0.
- R10: If POLL_MAX samples are all low, the sequence ends at the last one with both `done_o` and `timeout_o` 1.
- R11: A start pulse while `busy_o` is 1 has no effect on any output or on the timing.
- R12: `done_o` and `timeout_o` hold until the next start. A start in the done state restarts the full sequence: all resets are reasserted, the endpoint reset goes low, and `timeout_o` and `done_o` clear on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle or done |
| link_up_i | input | 1 | Link-up status from the core |
| ep_rst_n_o | output | 1 | Endpoint reset, active low |
| bus_rst_o | output | 1 | Bus-interface domain reset |
| phy_rst_o | output | 1 | PHY domain reset |
| core_rst_o | output | 1 | Core domain reset |
| por_rst_o | output | 1 | Power-on domain reset |
| axi_rst_o | output | 1 | AXI domain reset |
| iface_clk_en_o | output | 1 | Interface clock enable |
| phy_clk_en_o | output | 1 | PHY clock enable |
| core_clk_en_o | output | 1 | Core clock enable |
| wr_en_o | output | 1 | Register write strobe |
| wr_sel_o | output | 3 | Target word: 0 PHY ctrl, 1 de-emphasis, 2 swing, 3 refclk, 4 system ctrl |
| wr_data_o | output | 32 | Value to write |
| train_en_o | output | 1 | Link training enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (sticky) |
| timeout_o | output | 1 | Link did not come up (sticky) |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that `link_up_i` only changes between clock edges. They also assume that every microsecond parameter and `CYC_PER_US` are at least 1, so that each wait lasts at least one cycle. The stimulus drives both inputs only on falling edges. It uses small nonzero timing parameters, with link-up profiles that rise early, rise on the last sample, pulse only between samples, or never rise. It also places start pulses at random points inside a busy sequence and right after done.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_EPHOLD, S_CLK0, S_CLK1, S_CLK2, S_BUSWAIT,
    S_WPHY, S_WDEEM, S_WSWING, S_WREF,
    S_RPHY, S_RCORE, S_RPOR, S_RAXI,
    S_SETTLE, S_EPREL, S_TRAIN, S_POLL, S_DONE
  } bsq_state_e;

  localparam logic [2:0] SEL_PHYCTL = 3'd0;
  localparam logic [2:0] SEL_DEEMPH = 3'd1;
  localparam logic [2:0] SEL_SWING  = 3'd2;
  localparam logic [2:0] SEL_REFCLK = 3'd3;
  localparam logic [2:0] SEL_SYSCTL = 3'd4;

  // place a value of the given width at bit position lo
  function automatic logic [31:0] put_field(input logic [31:0] v, input int lo, input int width);
    logic [31:0] m;
    m = (32'd1 << width) - 32'd1;
    return (v & m) << lo;
  endfunction

  function automatic logic [31:0] phy_ctrl_word();
    // termination offset 7 at 20:16; power-down bit 0 left clear
    return put_field(32'd7, 16, 5);
  endfunction

  function automatic logic [31:0] deemph_word();
    return put_field(32'h18, 16, 6) | put_field(32'h18, 8, 6) | put_field(32'h22, 0, 6);
  endfunction

  function automatic logic [31:0] swing_word();
    return put_field(32'h78, 8, 7) | put_field(32'h78, 0, 7);
  endfunction

  function automatic logic [31:0] refclk_word();
    // bit 16 set, bit 12 cleared
    return put_field(32'd1, 16, 1);
  endfunction

  function automatic logic [31:0] sysctl_word();
    return put_field(32'd1, 0, 1);
  endfunction

endpackage

// File: rtl/bsq_timer.sv
module bsq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R2: an expired timer stays expired until reloaded
  a_r2_tmr_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

  // R2: a load of length above one leaves the timer running
  a_r2_tmr_runs : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i > TW'(1)) |=> !zero_o);

endmodule

// File: rtl/bsq_outdec.sv
module bsq_outdec
  import bsq_pkg::*;
(
  input  bsq_state_e  st_i,
  output logic        ep_rst_n_o,
  output logic        bus_rst_o,
  output logic        phy_rst_o,
  output logic        core_rst_o,
  output logic        por_rst_o,
  output logic        axi_rst_o,
  output logic        iface_clk_en_o,
  output logic        phy_clk_en_o,
  output logic        core_clk_en_o,
  output logic        wr_en_o,
  output logic [2:0]  wr_sel_o,
  output logic [31:0] wr_data_o,
  output logic        train_en_o,
  output logic        busy_o,
  output logic        done_o
);
  // States are ordered along the sequence, so each output is a threshold.
  always_comb begin
    ep_rst_n_o     = (st_i >= S_EPREL);
    bus_rst_o      = (st_i <  S_BUSWAIT);
    phy_rst_o      = (st_i <  S_RPHY);
    core_rst_o     = (st_i <  S_RCORE);
    por_rst_o      = (st_i <  S_RPOR);
    axi_rst_o      = (st_i <  S_RAXI);
    iface_clk_en_o = (st_i >= S_CLK0);
    phy_clk_en_o   = (st_i >= S_CLK1);
    core_clk_en_o  = (st_i >= S_CLK2);
    train_en_o     = (st_i >= S_TRAIN);
    busy_o         = (st_i != S_IDLE) && (st_i != S_DONE);
    done_o         = (st_i == S_DONE);
  end

  always_comb begin
    wr_en_o   = 1'b1;
    wr_sel_o  = SEL_PHYCTL;
    wr_data_o = '0;
    unique case (st_i)
      S_WPHY:   begin wr_sel_o = SEL_PHYCTL; wr_data_o = phy_ctrl_word(); end
      S_WDEEM:  begin wr_sel_o = SEL_DEEMPH; wr_data_o = deemph_word();   end
      S_WSWING: begin wr_sel_o = SEL_SWING;  wr_data_o = swing_word();    end
      S_WREF:   begin wr_sel_o = SEL_REFCLK; wr_data_o = refclk_word();   end
      S_TRAIN:  begin wr_sel_o = SEL_SYSCTL; wr_data_o = sysctl_word();   end
      default:  wr_en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
  import bsq_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int EP_HOLD_US = 10000,
  parameter int BUS_GAP_US = 1,
  parameter int SETTLE_US  = 10000,
  parameter int EP_REL_US  = 10000,
  parameter int POLL_US    = 10000,
  parameter int POLL_MAX   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        link_up_i,
  output logic        ep_rst_n_o,
  output logic        bus_rst_o,
  output logic        phy_rst_o,
  output logic        core_rst_o,
  output logic        por_rst_o,
  output logic        axi_rst_o,
  output logic        iface_clk_en_o,
  output logic        phy_clk_en_o,
  output logic        core_clk_en_o,
  output logic        wr_en_o,
  output logic [2:0]  wr_sel_o,
  output logic [31:0] wr_data_o,
  output logic        train_en_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_EP   = EP_HOLD_US * CYC_PER_US;
  localparam int T_BUS  = BUS_GAP_US * CYC_PER_US;
  localparam int T_SET  = SETTLE_US  * CYC_PER_US;
  localparam int T_EPR  = EP_REL_US  * CYC_PER_US;
  localparam int T_POLL = POLL_US    * CYC_PER_US;
  localparam int MAXC   = imax(imax(imax(T_EP, T_BUS), imax(T_SET, T_EPR)), T_POLL);
  localparam int TW     = $clog2(MAXC + 1);
  localparam int PCW    = $clog2(POLL_MAX + 1);

  // dwell length of a wait state; zero marks a single-cycle state
  function automatic logic [TW-1:0] dwell(input bsq_state_e s);
    case (s)
      S_EPHOLD:  return TW'(T_EP);
      S_BUSWAIT: return TW'(T_BUS);
      S_SETTLE:  return TW'(T_SET);
      S_EPREL:   return TW'(T_EPR);
      S_POLL:    return TW'(T_POLL);
      default:   return '0;
    endcase
  endfunction

  bsq_state_e     st_q, st_d;
  logic           tmr_zero, tmr_load, poll_again, accept, to_set;
  logic [TW-1:0]  tmr_len;
  logic [PCW-1:0] pcnt_q;
  logic           to_q;

  always_comb begin
    st_d       = st_q;
    accept     = 1'b0;
    poll_again = 1'b0;
    to_set     = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE: if (start_i) begin st_d = S_EPHOLD; accept = 1'b1; end
      S_EPHOLD:  if (tmr_zero) st_d = S_CLK0;
      S_CLK0:    st_d = S_CLK1;
      S_CLK1:    st_d = S_CLK2;
      S_CLK2:    st_d = S_BUSWAIT;
      S_BUSWAIT: if (tmr_zero) st_d = S_WPHY;
      S_WPHY:    st_d = S_WDEEM;
      S_WDEEM:   st_d = S_WSWING;
      S_WSWING:  st_d = S_WREF;
      S_WREF:    st_d = S_RPHY;
      S_RPHY:    st_d = S_RCORE;
      S_RCORE:   st_d = S_RPOR;
      S_RPOR:    st_d = S_RAXI;
      S_RAXI:    st_d = S_SETTLE;
      S_SETTLE:  if (tmr_zero) st_d = S_EPREL;
      S_EPREL:   if (tmr_zero) st_d = S_TRAIN;
      S_TRAIN:   st_d = S_POLL;
      S_POLL: if (tmr_zero) begin
        if (link_up_i)                         st_d = S_DONE;
        else if (pcnt_q == PCW'(POLL_MAX - 1)) begin st_d = S_DONE; to_set = 1'b1; end
        else                                   poll_again = 1'b1;
      end
      default:   st_d = S_IDLE;
    endcase
  end

  assign tmr_len  = dwell(st_d);
  assign tmr_load = ((st_d != st_q) && (tmr_len != '0)) || poll_again;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pcnt_q <= '0;
      to_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_TRAIN)  pcnt_q <= '0;
      else if (poll_again)  pcnt_q <= pcnt_q + PCW'(1);
      if (accept)           to_q <= 1'b0;
      else if (to_set)      to_q <= 1'b1;
    end
  end

  assign timeout_o = to_q;

  bsq_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  bsq_outdec u_dec (
    .st_i           (st_q),
    .ep_rst_n_o     (ep_rst_n_o),
    .bus_rst_o      (bus_rst_o),
    .phy_rst_o      (phy_rst_o),
    .core_rst_o     (core_rst_o),
    .por_rst_o      (por_rst_o),
    .axi_rst_o      (axi_rst_o),
    .iface_clk_en_o (iface_clk_en_o),
    .phy_clk_en_o   (phy_clk_en_o),
    .core_clk_en_o  (core_clk_en_o),
    .wr_en_o        (wr_en_o),
    .wr_sel_o       (wr_sel_o),
    .wr_data_o      (wr_data_o),
    .train_en_o     (train_en_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  // R3: register writes only once the bus interface is out of reset and clocked
  a_r3_wr_after_bus : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (!bus_rst_o && core_clk_en_o));

  // R7: a released domain implies every earlier domain released
  a_r7_rel_order : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !axi_rst_o |-> (!por_rst_o && !core_rst_o && !phy_rst_o && !bus_rst_o));

  // R8: training only with the endpoint out of reset
  a_r8_ep_before_train : assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_en_o |-> ep_rst_n_o);

  // R9: a clean finish follows a high link sample
  a_r9_done_cause : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !timeout_o) |-> $past(link_up_i));

  // R10: timeout only at the last allowed sample, and only with done
  a_r10_timeout_count : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(pcnt_q) == PCW'(POLL_MAX - 1)));
  a_r10_timeout_done : assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  // R11: a start seen while busy does not restart the hold
  a_r11_busy_ignore : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (st_q != S_EPHOLD || $past(st_q) == S_EPHOLD));

  // R12: done and timeout hold without a new start
  a_r12_done_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(timeout_o)));

endmodule

// File: tb/sim_pcie_bringup_seq.sv
`timescale 1ns/1ps
module sim_pcie_bringup_seq;
  localparam int CPU = 2, EPU = 3, BGU = 1, STU = 4, ERU = 3, PLU = 2, PMAX = 3;
  localparam int T_EP = EPU*CPU, T_BUS = BGU*CPU, T_SET = STU*CPU, T_EPR = ERU*CPU, TP = PLU*CPU;
  localparam int O_CLK0  = T_EP;
  localparam int O_BUS   = O_CLK0 + 3;
  localparam int O_WR0   = O_BUS + T_BUS;
  localparam int O_REL0  = O_WR0 + 4;
  localparam int O_SET   = O_REL0 + 4;
  localparam int O_EPREL = O_SET + T_SET;
  localparam int O_TRAIN = O_EPREL + T_EPR;
  localparam int O_POLL  = O_TRAIN + 1;

  logic clk = 0, rst_n = 0, start = 0, link = 0;
  logic ep_rst_n, bus_rst, phy_rst, core_rst, por_rst, axi_rst;
  logic ic_en, pc_en, cc_en, wr_en, train_en, busy, done, tmo;
  logic [2:0] wr_sel;
  logic [31:0] wr_data;
  int checks = 0, errors = 0;
  bit prev_done = 0;

  always #4 clk = ~clk;

  pcie_bringup_seq #(.CYC_PER_US(CPU), .EP_HOLD_US(EPU), .BUS_GAP_US(BGU), .SETTLE_US(STU),
    .EP_REL_US(ERU), .POLL_US(PLU), .POLL_MAX(PMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_up_i(link),
    .ep_rst_n_o(ep_rst_n), .bus_rst_o(bus_rst), .phy_rst_o(phy_rst), .core_rst_o(core_rst),
    .por_rst_o(por_rst), .axi_rst_o(axi_rst), .iface_clk_en_o(ic_en), .phy_clk_en_o(pc_en),
    .core_clk_en_o(cc_en), .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .train_en_o(train_en), .busy_o(busy), .done_o(done), .timeout_o(tmo));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input int v, input int lo);
    return 32'(v) << lo;
  endfunction

  function automatic logic [31:0] exp_word(input int sel);
    case (sel)
      0: return fld(7, 16);
      1: return fld(8'h18, 16) | fld(8'h18, 8) | 32'h22;
      2: return fld(8'h78, 8) | 32'h78;
      3: return fld(1, 16);
      default: return 32'h1;
    endcase
  endfunction

  // link value seen by the edge numbered e
  function automatic bit link_at(input int e, input int L, input int F);
    return (e - 1 >= L) && (e - 1 < F);
  endfunction

  function automatic void calc_done(input int L, input int F, output int D, output bit to);
    D = O_POLL + TP*PMAX; to = 1;
    for (int i = 1; i <= PMAX; i++)
      if (link_at(O_POLL + TP*i, L, F)) begin D = O_POLL + TP*i; to = 0; break; end
  endfunction

  task automatic compare(input int k, input int D, input bit to);
    string s;
    int ws;
    bit we;
    s = $sformatf(" k=%0d", k);
    ws = (k >= O_WR0 && k < O_WR0 + 4) ? k - O_WR0 : 4;
    we = (k >= O_WR0 && k < O_WR0 + 4) || (k == O_TRAIN);
    chk({"R2 iface clk", s}, 32'(ic_en), 32'(k >= O_CLK0));
    chk({"R2 phy clk", s},   32'(pc_en), 32'(k >= O_CLK0 + 1));
    chk({"R2 core clk", s},  32'(cc_en), 32'(k >= O_CLK0 + 2));
    chk({"R3 bus rst", s},   32'(bus_rst), 32'(k < O_BUS));
    chk({"R7 phy rst", s},   32'(phy_rst), 32'(k < O_REL0));
    chk({"R7 core rst", s},  32'(core_rst), 32'(k < O_REL0 + 1));
    chk({"R7 por rst", s},   32'(por_rst), 32'(k < O_REL0 + 2));
    chk({"R7 axi rst", s},   32'(axi_rst), 32'(k < O_REL0 + 3));
    chk({"R8 ep rst_n", s},  32'(ep_rst_n), 32'(k >= O_EPREL));
    chk({"R8 train en", s},  32'(train_en), 32'(k >= O_TRAIN));
    chk({"R3 wr_en", s},     32'(wr_en), 32'(we));
    if (we) begin
      case (ws)
        0: begin chk({"R4 sel", s}, 32'(wr_sel), 0); chk({"R4 data", s}, wr_data, exp_word(0)); end
        1, 2: begin chk({"R5 sel", s}, 32'(wr_sel), 32'(ws)); chk({"R5 data", s}, wr_data, exp_word(ws)); end
        3: begin chk({"R6 sel", s}, 32'(wr_sel), 3); chk({"R6 data", s}, wr_data, exp_word(3)); end
        default: begin chk({"R8 sel", s}, 32'(wr_sel), 4); chk({"R8 data", s}, wr_data, exp_word(4)); end
      endcase
    end
    chk({"R9 busy", s}, 32'(busy), 32'(k < D));
    chk({(k > D) ? "R12 done hold" : "R9 done", s}, 32'(done), 32'(k >= D));
    chk({"R10 timeout", s}, 32'(tmo), 32'(k >= D && to));
  endtask

  task automatic run_seq(input int L, input int F, input int xk);
    int D;
    bit to;
    calc_done(L, F, D, to);
    @(negedge clk);
    start = 1; link = 0;
    for (int k = 0; k <= D + 3; k++) begin
      @(negedge clk);
      if (k == 0 && prev_done) begin
        chk("R12 restart bus rst", 32'(bus_rst), 1);
        chk("R12 restart ep rst_n", 32'(ep_rst_n), 0);
        chk("R12 restart timeout clear", 32'(tmo), 0);
      end
      compare(k, D, to);
      start = (k == xk);
      link = (k >= L) && (k < F);
    end
    start = 0;
    if (xk >= 0) begin
      chk("R11 done after ignored start", 32'(done), 1);
      chk("R11 timeout after ignored start", 32'(tmo), 32'(to));
    end
    prev_done = 1;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240517;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ep rst_n", 32'(ep_rst_n), 0);
    chk("R1 domain resets", 32'({bus_rst, phy_rst, core_rst, por_rst, axi_rst}), 32'h1f);
    chk("R1 clocks", 32'({ic_en, pc_en, cc_en}), 0);
    chk("R1 status", 32'({wr_en, train_en, busy, done, tmo}), 0);
    run_seq(0, 100000, -1);                          // R9 first sample high
    run_seq(100000, 100001, -1);                     // R10 never up
    run_seq(O_POLL + 1, O_POLL + 2, -1);             // R9 pulse between samples ignored
    run_seq(O_POLL + TP*PMAX - 1, 100000, -1);       // R9 up on last sample
    run_seq(O_POLL + TP, 100000, 20);                // R11 start while busy
    for (int r = 0; r < 8; r++) begin
      int L, F, xk;
      L = int'($urandom_range(0, O_POLL + TP*PMAX + 2));
      F = L + int'($urandom_range(1, 3*TP));
      xk = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, O_POLL)) : -1;
      run_seq(L, F, xk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule